// File: doc/BRIEF.md
# Warp Divergence Reconvergence Stack

This block keeps the control-flow stack of one four-lane warp. Each stack slot holds three items: the PC the slot will run next, the PC where its lanes rejoin, and the set of lanes active in that slot. The warp always runs at the PC and lane mask of the top slot. A branch on which the active lanes disagree splits the warp. The top slot is then parked at the rejoin PC. A slot for the fall-through lanes is pushed, and a slot for the taken lanes is pushed above it. The two paths therefore run one after the other, taken path first. Each path slot is discarded once the PC it presents equals its rejoin PC. The warp then resumes at the rejoin point with the lanes it had before the split.

Each executed instruction is handed to the block as one step on a valid/ready interface. A step carries four items: a branch flag, a per-lane taken mask, the branch target, and the sequential (fall-through) PC. For a branch, the immediate post-dominator PC is also given as the rejoin PC. A step transfers when `step_valid` and `step_ready` are both high. Nothing is taken while either is low, and the producer must hold the step until it transfers. `step_ready` is high from reset on and falls only when the stack overflows. It stays low until reset, because the stack contents can no longer be trusted after an overflow. The results appear on `warp_pc` and `warp_mask` one clock after the step transfers.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset, `warp_pc` equals the START_PC parameter, `warp_mask` is all ones (bit i stands for lane i), `overflow` is low and `step_ready` is high.
- R2: A transferred step with `step_branch` low sets `warp_pc` to `step_seq_pc` on the next cycle and leaves `warp_mask` unchanged, unless R8 applies.
- R3: A branch step is uniform when the taken bits of the active lanes are all set or all clear. A uniform branch moves to `step_taken_pc` or to `step_seq_pc` respectively, pushes nothing, and leaves the mask unchanged. Taken bits of inactive lanes have no effect.
- R4: A divergent branch makes the next `warp_pc` equal to `step_taken_pc`, and the next `warp_mask` equal to the active lanes whose taken bit is set.
- R5: When the taken path presents its rejoin PC as its next PC, the following cycle shows the split's `step_seq_pc` with the active lanes whose taken bit was clear.
- R6: When that fall-through path in turn presents the rejoin PC, the following cycle shows the rejoin PC with the mask that was active before the split.
- R7: The bottom slot has no rejoin PC and is never removed. With one slot in use, every non-divergent step only updates its PC. The number of slots in use stays between 1 and DEPTH.
- R8: A non-divergent step whose resulting PC equals the top slot's rejoin PC removes that slot in the same step. The slot beneath it drives the outputs on the next cycle.
- R9: A divergent branch that finds fewer than two free slots sets `overflow`. In that case `warp_pc` and `warp_mask` stay unchanged, and `step_ready` drops. Both stay that way until reset.
- R10: While no step transfers, `warp_pc` and `warp_mask` hold their values, whatever the other step inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_valid | input | 1 | A step is offered |
| step_ready | output | 1 | The block accepts a step; low after overflow |
| step_branch | input | 1 | The step is a conditional branch |
| step_taken_mask | input | LANES | Per-lane branch outcome, bit i for lane i |
| step_taken_pc | input | PCW | Branch target |
| step_seq_pc | input | PCW | Sequential / fall-through PC |
| step_reconv_pc | input | PCW | Rejoin PC used when the branch splits |
| warp_pc | output | PCW | PC the warp runs next |
| warp_mask | output | LANES | Lanes active for that PC |
| overflow | output | 1 | Sticky: a split found the stack too full |

## Verification
Two events can share a single step: a branch updating the top slot and that slot being removed. A uniform branch whose target is the top slot's rejoin PC does both at once, and the outputs must then come from the slot beneath it rather than from the branch target. Directed sequences build nested splits and end their paths with exactly such branches. A random phase presents the top rejoin PC as the next PC on about a third of its steps, with uniform and divergent taken masks mixed in. After every step, the bench compares the outputs against a stack model built from the requirements.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  typedef enum logic [2:0] {
    ST_HOLD,
    ST_SEQ,
    ST_UNIFORM,
    ST_SPLIT,
    ST_OVERFLOW
  } step_kind_e;
endpackage

// File: rtl/rcs_classify.sv
module rcs_classify #(
  parameter int LANES = 4,
  parameter int PCW   = 16,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1) + 1
) (
  input  logic                    go,
  input  logic                    branch,
  input  logic [LANES-1:0]        taken_mask,
  input  logic [PCW-1:0]          taken_pc,
  input  logic [PCW-1:0]          seq_pc,
  input  logic [LANES-1:0]        act_mask,
  input  logic [PCW-1:0]          top_rpc,
  input  logic [CW-1:0]           depth,
  output rcs_pkg::step_kind_e     kind,
  output logic [PCW-1:0]          new_pc,
  output logic [LANES-1:0]        tk_sub,
  output logic [LANES-1:0]        nt_sub,
  output logic                    pop
);
  import rcs_pkg::*;

  localparam logic [CW-1:0] SPLIT_LIMIT = CW'(DEPTH - 2);
  localparam logic [CW-1:0] ONE_SLOT    = CW'(1);

  assign tk_sub = taken_mask & act_mask;
  assign nt_sub = act_mask & ~taken_mask;

  always_comb begin
    kind   = ST_HOLD;
    new_pc = seq_pc;
    if (go) begin
      if (!branch) begin
        kind = ST_SEQ;
      end else if (nt_sub == '0) begin
        kind   = ST_UNIFORM;
        new_pc = taken_pc;
      end else if (tk_sub == '0) begin
        kind = ST_UNIFORM;
      end else if (depth > SPLIT_LIMIT) begin
        kind = ST_OVERFLOW;
      end else begin
        kind = ST_SPLIT;
      end
    end
  end

  assign pop = ((kind == ST_SEQ) || (kind == ST_UNIFORM)) &&
               (depth > ONE_SLOT) && (new_pc == top_rpc);
endmodule

// File: rtl/rcs_store.sv
module rcs_store #(
  parameter int LANES             = 4,
  parameter int PCW               = 16,
  parameter int DEPTH             = 8,
  parameter logic [PCW-1:0] START_PC = '0,
  localparam int CW               = $clog2(DEPTH + 1) + 1,
  localparam int IW               = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  rcs_pkg::step_kind_e kind,
  input  logic                pop,
  input  logic [PCW-1:0]      new_pc,
  input  logic [PCW-1:0]      taken_pc,
  input  logic [PCW-1:0]      seq_pc,
  input  logic [PCW-1:0]      reconv_pc,
  input  logic [LANES-1:0]    tk_sub,
  input  logic [LANES-1:0]    nt_sub,
  output logic [PCW-1:0]      top_pc,
  output logic [PCW-1:0]      top_rpc,
  output logic [LANES-1:0]    top_mask,
  output logic [CW-1:0]       depth
);
  import rcs_pkg::*;

  logic [CW-1:0]                 sp_q;
  logic [DEPTH-1:0][PCW-1:0]     pc_w;
  logic [DEPTH-1:0][PCW-1:0]     rpc_w;
  logic [DEPTH-1:0][LANES-1:0]   mask_w;
  logic                          upd;

  assign upd = (kind == ST_SEQ) || (kind == ST_UNIFORM);

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    localparam logic [CW-1:0] AT = CW'(e);
    logic [PCW-1:0]   pc_r;
    logic [PCW-1:0]   rpc_r;
    logic [LANES-1:0] mask_r;
    logic             is_top, is_fall, is_tkn;

    assign is_top  = (AT + CW'(1)) == sp_q;
    assign is_fall = AT == sp_q;
    assign is_tkn  = AT == (sp_q + CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pc_r   <= (e == 0) ? START_PC : '0;
        rpc_r  <= '0;
        mask_r <= (e == 0) ? '1 : '0;
      end else if (kind == ST_SPLIT) begin
        if (is_top) pc_r <= reconv_pc;
        if (is_fall) begin
          pc_r   <= seq_pc;
          rpc_r  <= reconv_pc;
          mask_r <= nt_sub;
        end
        if (is_tkn) begin
          pc_r   <= taken_pc;
          rpc_r  <= reconv_pc;
          mask_r <= tk_sub;
        end
      end else if (upd && is_top && !pop) begin
        pc_r <= new_pc;
      end
    end

    assign pc_w[e]   = pc_r;
    assign rpc_w[e]  = rpc_r;
    assign mask_w[e] = mask_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                sp_q <= CW'(1);
    else if (kind == ST_SPLIT) sp_q <= sp_q + CW'(2);
    else if (pop)              sp_q <= sp_q - CW'(1);
  end

  logic [IW-1:0] top_idx;
  assign top_idx  = IW'(sp_q - CW'(1));
  assign top_pc   = pc_w[top_idx];
  assign top_rpc  = rpc_w[top_idx];
  assign top_mask = mask_w[top_idx];
  assign depth    = sp_q;
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack #(
  parameter int LANES                = 4,
  parameter int PCW                  = 16,
  parameter int DEPTH                = 8,
  parameter logic [PCW-1:0] START_PC = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_valid,
  output logic             step_ready,
  input  logic             step_branch,
  input  logic [LANES-1:0] step_taken_mask,
  input  logic [PCW-1:0]   step_taken_pc,
  input  logic [PCW-1:0]   step_seq_pc,
  input  logic [PCW-1:0]   step_reconv_pc,
  output logic [PCW-1:0]   warp_pc,
  output logic [LANES-1:0] warp_mask,
  output logic             overflow
);
  import rcs_pkg::*;
  localparam int CW = $clog2(DEPTH + 1) + 1;

  step_kind_e       kind;
  logic [PCW-1:0]   new_pc, top_rpc;
  logic [LANES-1:0] tk_sub, nt_sub;
  logic             pop, err_q, go;
  logic [CW-1:0]    stack_depth;

  assign step_ready = !err_q;
  assign go         = step_valid && step_ready;

  rcs_classify #(.LANES(LANES), .PCW(PCW), .DEPTH(DEPTH)) u_classify (
    .go(go), .branch(step_branch), .taken_mask(step_taken_mask),
    .taken_pc(step_taken_pc), .seq_pc(step_seq_pc), .act_mask(warp_mask),
    .top_rpc(top_rpc), .depth(stack_depth), .kind(kind), .new_pc(new_pc),
    .tk_sub(tk_sub), .nt_sub(nt_sub), .pop(pop)
  );

  rcs_store #(.LANES(LANES), .PCW(PCW), .DEPTH(DEPTH), .START_PC(START_PC)) u_store (
    .clk(clk), .rst_n(rst_n), .kind(kind), .pop(pop), .new_pc(new_pc),
    .taken_pc(step_taken_pc), .seq_pc(step_seq_pc), .reconv_pc(step_reconv_pc),
    .tk_sub(tk_sub), .nt_sub(nt_sub), .top_pc(warp_pc), .top_rpc(top_rpc),
    .top_mask(warp_mask), .depth(stack_depth)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   err_q <= 1'b0;
    else if (kind == ST_OVERFLOW) err_q <= 1'b1;
  end

  assign overflow = err_q;
endmodule

// File: rtl/rcs_checker.sv
module rcs_checker #(
  parameter int LANES = 4,
  parameter int PCW   = 16,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step_valid,
  input logic             step_ready,
  input logic             step_branch,
  input logic [LANES-1:0] step_taken_mask,
  input logic [PCW-1:0]   step_taken_pc,
  input logic [PCW-1:0]   warp_pc,
  input logic [LANES-1:0] warp_mask,
  input logic             overflow,
  input logic [CW-1:0]    depth
);
  logic xfer, split_ok, all_taken;
  assign xfer      = step_valid && step_ready;
  assign split_ok  = xfer && step_branch &&
                     ((step_taken_mask & warp_mask) != '0) &&
                     ((warp_mask & ~step_taken_mask) != '0) &&
                     (int'(depth) <= DEPTH - 2);
  assign all_taken = xfer && step_branch && ((warp_mask & ~step_taken_mask) == '0);

  assert_mask_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    warp_mask != '0);

  assert_split_taken_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    split_ok |=> (warp_pc == $past(step_taken_pc)) &&
                 (warp_mask == $past(step_taken_mask & warp_mask)));

  assert_uniform_bottom_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (all_taken && depth == CW'(1)) |=> (warp_pc == $past(step_taken_pc)) && $stable(warp_mask));

  assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow && !step_ready);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(warp_pc) && $stable(warp_mask));

  assert_depth_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (depth >= CW'(1)) && (int'(depth) <= DEPTH));
endmodule

bind simt_reconv_stack rcs_checker #(.LANES(LANES), .PCW(PCW), .DEPTH(DEPTH)) u_rcs_checker (
  .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .step_ready(step_ready),
  .step_branch(step_branch), .step_taken_mask(step_taken_mask),
  .step_taken_pc(step_taken_pc), .warp_pc(warp_pc), .warp_mask(warp_mask),
  .overflow(overflow), .depth(stack_depth)
);

// File: tb/test_simt_reconv_stack.sv
module test_simt_reconv_stack;
  localparam int CLK_PERIOD = 10;
  localparam int LN = 4;
  localparam int PW = 16;
  localparam int TD = 5;
  localparam logic [PW-1:0] SPC = 16'h0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_valid = 1'b0, step_branch = 1'b0;
  logic step_ready, overflow;
  logic [LN-1:0] step_taken_mask = '0, warp_mask;
  logic [PW-1:0] step_taken_pc = '0, step_seq_pc = '0, step_reconv_pc = '0, warp_pc;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic [PW-1:0] m_pc [TD+2];
  logic [PW-1:0] m_rpc [TD+2];
  logic [LN-1:0] m_mask [TD+2];
  int m_sp;
  bit m_ovf;

  always #(CLK_PERIOD/2) clk = ~clk;

  simt_reconv_stack #(.LANES(LN), .PCW(PW), .DEPTH(TD), .START_PC(SPC)) i_simt_reconv_stack (
    .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .step_ready(step_ready),
    .step_branch(step_branch), .step_taken_mask(step_taken_mask),
    .step_taken_pc(step_taken_pc), .step_seq_pc(step_seq_pc),
    .step_reconv_pc(step_reconv_pc), .warp_pc(warp_pc), .warp_mask(warp_mask),
    .overflow(overflow)
  );

  function automatic logic [PW-1:0] exp_pc();
    return m_pc[m_sp-1];
  endfunction

  function automatic logic [LN-1:0] exp_mask();
    return m_mask[m_sp-1];
  endfunction

  task automatic check(input string req);
    n_chk++;
    if (warp_pc !== exp_pc()) begin
      n_bad++; $display("FAIL %s pc actual %h expected %h", req, warp_pc, exp_pc());
    end
    n_chk++;
    if (warp_mask !== exp_mask()) begin
      n_bad++; $display("FAIL %s mask actual %b expected %b", req, warp_mask, exp_mask());
    end
    n_chk++;
    if (overflow !== m_ovf || step_ready !== !m_ovf) begin
      n_bad++; $display("FAIL %s ovf/ready actual %b/%b expected %b/%b",
                        req, overflow, step_ready, m_ovf, !m_ovf);
    end
  endtask

  task automatic model(input bit br, input logic [LN-1:0] tm,
                       input logic [PW-1:0] tpc, spc, rpc);
    logic [LN-1:0] act, tk, nt;
    logic [PW-1:0] np;
    act = m_mask[m_sp-1];
    tk = tm & act;
    nt = act & ~tm;
    np = spc;
    if (br && nt == '0) np = tpc;
    if (br && tk != '0 && nt != '0) begin
      if (m_sp + 2 > TD) m_ovf = 1'b1;
      else begin
        m_pc[m_sp-1] = rpc;
        m_pc[m_sp] = spc; m_rpc[m_sp] = rpc; m_mask[m_sp] = nt;
        m_pc[m_sp+1] = tpc; m_rpc[m_sp+1] = rpc; m_mask[m_sp+1] = tk;
        m_sp += 2;
      end
    end else if (m_sp > 1 && np == m_rpc[m_sp-1]) m_sp--;
    else m_pc[m_sp-1] = np;
  endtask

  task automatic do_reset(input string req);
    @(negedge clk);
    rst_n = 1'b0; step_valid = 1'b0;
    m_sp = 1; m_ovf = 1'b0; m_pc[0] = SPC; m_rpc[0] = '0; m_mask[0] = '1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req);
  endtask

  task automatic step(input bit v, input bit br, input logic [LN-1:0] tm,
                      input logic [PW-1:0] tpc, spc, rpc, input string req);
    @(negedge clk);
    step_valid = v; step_branch = br; step_taken_mask = tm;
    step_taken_pc = tpc; step_seq_pc = spc; step_reconv_pc = rpc;
    if (v && !m_ovf) model(br, tm, tpc, spc, rpc);
    @(negedge clk);
    step_valid = 1'b0;
    check(req);
  endtask

  initial begin
    void'($urandom(32'd4471));
    do_reset("R1 reset state");
    step(1, 0, 4'b0000, 16'h0, 16'h0104, 16'h0, "R2 sequential step");
    step(0, 1, 4'b1010, 16'h0AAA, 16'h0BBB, 16'h0CCC, "R10 idle step ignored");
    step(1, 1, 4'b1111, 16'h0200, 16'h0108, 16'h0, "R3 all taken");
    step(1, 0, 4'b0000, 16'h0, 16'h0000, 16'h0, "R7 bottom never pops");
    step(1, 1, 4'b0000, 16'h0300, 16'h0204, 16'h0, "R3 none taken");
    // split 1110 / 0001 rejoining at 0x0400
    step(1, 1, 4'b1110, 16'h0210, 16'h0208, 16'h0400, "R4 split taken first");
    step(1, 1, 4'b0001, 16'h0999, 16'h0214, 16'h0, "R3 inactive lane bit ignored");
    step(1, 0, 4'b0000, 16'h0, 16'h0400, 16'h0, "R5 fall path after taken rejoins");
    step(1, 0, 4'b0000, 16'h0, 16'h020C, 16'h0, "R2 step in fall path");
    step(1, 0, 4'b0000, 16'h0, 16'h0400, 16'h0, "R6 full mask at rejoin");
    // branch update and pop in the same step
    step(1, 1, 4'b0011, 16'h0500, 16'h0404, 16'h0600, "R4 second split");
    step(1, 1, 4'b1111, 16'h0600, 16'h0504, 16'h0, "R8 uniform branch to rejoin pops");
    step(1, 1, 4'b0000, 16'h0777, 16'h0600, 16'h0, "R8 fall path pops");
    // nested splits until the stack is too full
    step(1, 1, 4'b1110, 16'h0700, 16'h0704, 16'h0900, "R4 nest level one");
    step(1, 1, 4'b1100, 16'h0710, 16'h0714, 16'h0800, "R4 nest level two");
    step(1, 1, 4'b1000, 16'h0720, 16'h0724, 16'h0750, "R9 overflow raised");
    step(1, 0, 4'b0000, 16'h0, 16'h0800, 16'h0, "R9 frozen after overflow");
    do_reset("R1 reset clears overflow");
    for (int i = 0; i < 600; i++) begin
      logic [PW-1:0] spc;
      spc = PW'($urandom);
      if (m_sp > 1 && $urandom % 3 == 0) spc = m_rpc[m_sp-1];
      step(($urandom % 8) != 0, $urandom % 2 == 1, LN'($urandom), PW'($urandom),
           spc, PW'($urandom), "R2 R3 R4 R8 random");
      if (m_ovf || (i % 60) == 59) do_reset("R1 random reset");
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule